// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one or two DDR2 ranks from reset to an operational state with no software involvement. After reset it keeps the clock enable low. It waits until a minimum stretch of stable clock has passed and the PHY delay-locked loop reports lock. It then walks a fixed list of DRAM commands per rank and presents each command on a valid/ready command port. It pauses for the required intervals between some of the commands. Once every enabled rank is configured, it turns on periodic refresh and flags that initialization is complete.

The four mode-register words come in on plain input pins. The sequencer derives every mode-register write from them. The DLL-reset bit of the mode register is set on the first write and cleared on the second. The DLL-enable bit of extended register 1 is always forced to enabled. Its off-chip-driver calibration field is driven to the default code and then back to the exit code. Every wait is given as a parameter in time units or clocks and is converted to a clock count at elaboration from the clock frequency parameter.

The command port follows valid/ready rules. A command stays on the bus, unchanged, from the cycle `cmd_valid` rises until the cycle in which `cmd_ready` is also high. The sequencer moves to the next step only after that handshake. Holding `cmd_ready` low stalls the whole sequence without losing or reordering anything. The wait intervals are counted from the accepting cycle, so back-pressure never shortens them.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cke`, `cmd_valid`, `refresh_en` and `init_done` are all 0.
- R2: The first command is presented no earlier than PWRUP_CYC = CLK_MHZ*PWRUP_US cycles after reset release, and not before `dll_locked` is high. With lock already present, it appears in cycle PWRUP_CYC+1. Otherwise it appears one cycle after lock is seen. While `cke` is low, only a NOP (type 0) may be presented.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_type`, `cmd_chip`, `cmd_bank` and `cmd_addr` hold their values. The sequence advances one step per handshake.
- R4: Each rank receives exactly 12 commands in this order, with type codes NOP=0, PALL=1, MODE=2, REF=3 and, for MODE, bank 0 = mode register, 1..3 = extended registers 1..3:
  - NOP
  - PALL
  - MODE bank 2 (`emr2_val`)
  - MODE bank 3 (`emr3_val`)
  - MODE bank 1 (DLL enable)
  - MODE bank 0 (DLL reset)
  - PALL
  - REF
  - REF
  - MODE bank 0 (no DLL reset)
  - MODE bank 1 (calibration default)
  - MODE bank 1 (calibration exit)
- R5: `cke` rises in the cycle after the first NOP is accepted and stays high until reset.
- R6: After the NOP is accepted, `cmd_valid` stays low for exactly CKE_CYC = ceil(CKE_NS*CLK_MHZ/1000) cycles. Consecutive commands with no required wait, including the step from the last command of rank 0 to the NOP of rank 1, are presented back to back.
- R7: After the mode-register write without DLL reset is accepted, `cmd_valid` stays low for exactly MRS_WAIT_CYC cycles.
- R8: The first mode-register write carries `mr_val` with address bit 8 set. The second carries `mr_val` with bit 8 cleared. All other bits equal `mr_val`.
- R9: All three extended-register-1 writes carry `emr1_val` with bit 0 cleared (DLL enabled). Bits 9..7 are 000 on the DLL-enable and calibration-exit writes and 111 on the calibration-default write. All other bits equal `emr1_val`.
- R10: With `two_rank_en` low, every command has `cmd_chip` = 0. With it high, the full 12-command series runs for chip 0 and then for chip 1.
- R11: `refresh_en` and `init_done` rise together in the cycle after the last command of the last rank is accepted. They stay high until reset, and no command is presented afterwards.
- R12: Every PALL carries address bit 10 set and all other address bits 0. NOP and REF carry address 0 and bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dll_locked | input | 1 | PHY DLL lock indication |
| two_rank_en | input | 1 | Configure chip 1 after chip 0 |
| mr_val | input | ADDR_W | Mode register operating value |
| emr1_val | input | ADDR_W | Extended mode register 1 value |
| emr2_val | input | ADDR_W | Extended mode register 2 value |
| emr3_val | input | ADDR_W | Extended mode register 3 value |
| cmd_ready | input | 1 | Command port accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_type | output | 3 | Command code: NOP=0, PALL=1, MODE=2, REF=3 |
| cmd_chip | output | 1 | Target rank |
| cmd_bank | output | BANK_W | Bank address (mode register select for MODE) |
| cmd_addr | output | ADDR_W | Row/mode address bits |
| cke | output | 1 | DRAM clock enable |
| refresh_en | output | 1 | Enables the periodic refresh counter |
| init_done | output | 1 | Initialization complete |

## Verification
The assertions watch, on every cycle, the properties that hold locally:
- the payload is held stable under back-pressure;
- no command other than NOP is presented while the clock enable is low;
- the clock enable and the completion flags never fall once they have risen;
- nothing is issued after completion;
- a single-rank run never addresses chip 1.

Only the bench's scenarios can show the properties that need the whole run:
- the exact command order and the derived mode-register words;
- the exact lengths of the power-up, clock-enable and post-mode-register waits;
- the cycle in which the clock enable rises;
- the late-lock delay;
- the repeat of the series for the second rank.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd1,
    CMD_MODE = 3'd2,
    CMD_REF  = 3'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_PWRUP,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    WT_NONE,
    WT_CKE,
    WT_MRS
  } wait_e;

  localparam int unsigned STEPS  = 12;
  localparam int unsigned STEP_W = 4;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int unsigned W    = 8,
  parameter int unsigned INIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= W'(INIT);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/ddr2_init_cmdgen.sv
module ddr2_init_cmdgen
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BANK_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  output cmd_e              typ,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output wait_e             wsel
);

  localparam logic [ADDR_W-1:0] BIT_A0  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BIT_A8  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] BIT_A10 = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] OCD_FLD = ADDR_W'(7) << 7;

  logic [ADDR_W-1:0] emr1_base;
  assign emr1_base = emr1_val & ~(OCD_FLD | BIT_A0);

  always_comb begin
    typ  = CMD_NOP;
    bank = '0;
    addr = '0;
    wsel = WT_NONE;
    case (step)
      4'd0:  wsel = WT_CKE;
      4'd1:  begin typ = CMD_PALL; addr = BIT_A10; end
      4'd2:  begin typ = CMD_MODE; bank = BANK_W'(2); addr = emr2_val; end
      4'd3:  begin typ = CMD_MODE; bank = BANK_W'(3); addr = emr3_val; end
      4'd4:  begin typ = CMD_MODE; bank = BANK_W'(1); addr = emr1_base; end
      4'd5:  begin typ = CMD_MODE; addr = mr_val | BIT_A8; end
      4'd6:  begin typ = CMD_PALL; addr = BIT_A10; end
      4'd7:  typ = CMD_REF;
      4'd8:  typ = CMD_REF;
      4'd9:  begin typ = CMD_MODE; addr = mr_val & ~BIT_A8; wsel = WT_MRS; end
      4'd10: begin typ = CMD_MODE; bank = BANK_W'(1); addr = emr1_base | OCD_FLD; end
      4'd11: begin typ = CMD_MODE; bank = BANK_W'(1); addr = emr1_base; end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned BANK_W       = 3,
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned PWRUP_US     = 200,
  parameter int unsigned CKE_NS       = 400,
  parameter int unsigned MRS_WAIT_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_locked,
  input  logic              two_rank_en,
  input  logic [ADDR_W-1:0] mr_val,
  input  logic [ADDR_W-1:0] emr1_val,
  input  logic [ADDR_W-1:0] emr2_val,
  input  logic [ADDR_W-1:0] emr3_val,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_type,
  output logic              cmd_chip,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cke,
  output logic              refresh_en,
  output logic              init_done
);

  localparam int unsigned PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int unsigned CKE_CYC   = (CKE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned MAX_A     = (PWRUP_CYC > CKE_CYC) ? PWRUP_CYC : CKE_CYC;
  localparam int unsigned MAX_W     = (MAX_A > MRS_WAIT_CYC) ? MAX_A : MRS_WAIT_CYC;
  localparam int unsigned TW        = $clog2(MAX_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  st_e               st;
  logic [STEP_W-1:0] step;
  logic              chip_q;
  logic              cke_q;
  logic              done_q;

  cmd_e              g_typ;
  logic [BANK_W-1:0] g_bank;
  logic [ADDR_W-1:0] g_addr;
  wait_e             g_wsel;

  logic              hs;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_done;

  ddr2_init_cmdgen #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_gen (
    .step     (step),
    .mr_val   (mr_val),
    .emr1_val (emr1_val),
    .emr2_val (emr2_val),
    .emr3_val (emr3_val),
    .typ      (g_typ),
    .bank     (g_bank),
    .addr     (g_addr),
    .wsel     (g_wsel)
  );

  assign hs       = (st == ST_ISSUE) && cmd_ready;
  assign tmr_load = hs && (g_wsel != WT_NONE);
  assign tmr_val  = (g_wsel == WT_CKE) ? TW'(CKE_CYC - 1) : TW'(MRS_WAIT_CYC - 1);

  ddr2_init_timer #(.W(TW), .INIT(PWRUP_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_PWRUP;
      step   <= '0;
      chip_q <= 1'b0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_PWRUP: if (tmr_done && dll_locked) st <= ST_ISSUE;
        ST_ISSUE: if (cmd_ready) begin
          if (g_typ == CMD_NOP) cke_q <= 1'b1;
          if (step == LAST_STEP) begin
            step <= '0;
            if (two_rank_en && !chip_q) begin
              chip_q <= 1'b1;
            end else begin
              st     <= ST_DONE;
              done_q <= 1'b1;
            end
          end else begin
            step <= step + 1'b1;
            if (g_wsel != WT_NONE) st <= ST_WAIT;
          end
        end
        ST_WAIT:  if (tmr_done) st <= ST_ISSUE;
        default:  st <= ST_DONE;
      endcase
    end
  end

  assign cmd_valid  = (st == ST_ISSUE);
  assign cmd_type   = g_typ;
  assign cmd_chip   = chip_q;
  assign cmd_bank   = g_bank;
  assign cmd_addr   = g_addr;
  assign cke        = cke_q;
  assign refresh_en = done_q;
  assign init_done  = done_q;

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dll_locked,
  input logic              two_rank_en,
  input logic              cmd_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_type,
  input logic              cmd_chip,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cke,
  input logic              refresh_en,
  input logic              init_done
);

  assert_hold_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_type) && $stable(cmd_chip)
                                && $stable(cmd_bank) && $stable(cmd_addr));

  assert_nop_only_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cke |-> cmd_type == 3'd0);

  assert_no_cmd_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_locked && !cke |-> !cmd_valid);

  assert_cke_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_refresh_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |=> refresh_en);

  assert_quiet_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid);

  assert_single_chip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !two_rank_en |-> !cmd_chip);

endmodule

bind ddr2_init_seq ddr2_init_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dll_locked  (dll_locked),
  .two_rank_en (two_rank_en),
  .cmd_ready   (cmd_ready),
  .cmd_valid   (cmd_valid),
  .cmd_type    (cmd_type),
  .cmd_chip    (cmd_chip),
  .cmd_bank    (cmd_bank),
  .cmd_addr    (cmd_addr),
  .cke         (cke),
  .refresh_en  (refresh_en),
  .init_done   (init_done)
);

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;

  localparam int PWRUP   = 125;
  localparam int CKE_W   = 50;
  localparam int MRS_W   = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dll_locked = 1'b0;
  logic        two_rank_en = 1'b0;
  logic [13:0] mr_val = '0, emr1_val = '0, emr2_val = '0, emr3_val = '0;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid;
  logic [2:0]  cmd_type;
  logic        cmd_chip;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_addr;
  logic        cke, refresh_en, init_done;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ddr2_init_seq #(.PWRUP_US(1)) dut (
    .clk(clk), .rst_n(rst_n), .dll_locked(dll_locked), .two_rank_en(two_rank_en),
    .mr_val(mr_val), .emr1_val(emr1_val), .emr2_val(emr2_val), .emr3_val(emr3_val),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_chip(cmd_chip), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cke(cke), .refresh_en(refresh_en), .init_done(init_done)
  );

  // cycle counter and monitor
  int cyc;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  int          n_hs, first_v, cke_rise, done_cyc, stab_err, post_err, nop_hs;
  logic [2:0]  h_typ [32];
  logic [2:0]  h_bank[32];
  logic [13:0] h_addr[32];
  logic        h_chip[32];
  int          h_cyc [32];
  logic        stall_prev;
  logic [20:0] held;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_hs = 0; first_v = -1; cke_rise = -1; done_cyc = -1;
      stab_err = 0; post_err = 0; nop_hs = -1; stall_prev = 0;
    end else begin
      if (cmd_valid && stall_prev && held != {cmd_type, cmd_chip, cmd_bank, cmd_addr})
        stab_err++;
      if (cmd_valid && first_v < 0) first_v = cyc;
      if (cke && cke_rise < 0) cke_rise = cyc;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (init_done && cmd_valid) post_err++;
      if (cmd_valid && cmd_ready && n_hs < 32) begin
        h_typ[n_hs] = cmd_type; h_bank[n_hs] = cmd_bank; h_addr[n_hs] = cmd_addr;
        h_chip[n_hs] = cmd_chip; h_cyc[n_hs] = cyc;
        if (nop_hs < 0 && cmd_type == 3'd0) nop_hs = cyc;
        n_hs++;
      end
      stall_prev = cmd_valid && !cmd_ready;
      held = {cmd_type, cmd_chip, cmd_bank, cmd_addr};
    end
  end

  // back-pressure driver
  logic       bp_on = 1'b0;
  logic [7:0] lfsr  = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = bp_on ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected command from the requirements: {type, bank, addr}
  function automatic logic [19:0] exp_cmd(int s, logic [13:0] mr, e1, e2, e3);
    logic [13:0] b1;
    b1 = e1 & ~14'h0381;
    case (s)
      0:  return {3'd0, 3'd0, 14'h0};
      1:  return {3'd1, 3'd0, 14'h0400};
      2:  return {3'd2, 3'd2, e2};
      3:  return {3'd2, 3'd3, e3};
      4:  return {3'd2, 3'd1, b1};
      5:  return {3'd2, 3'd0, mr | 14'h0100};
      6:  return {3'd1, 3'd0, 14'h0400};
      7:  return {3'd3, 3'd0, 14'h0};
      8:  return {3'd3, 3'd0, 14'h0};
      9:  return {3'd2, 3'd0, mr & ~14'h0100};
      10: return {3'd2, 3'd1, b1 | 14'h0380};
      default: return {3'd2, 3'd1, b1};
    endcase
  endfunction

  function automatic string step_req(int s);
    case (s)
      1, 6:     return "R12";
      5, 9:     return "R8";
      4, 10, 11: return "R9";
      default:  return "R4";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!cke && !cmd_valid && !refresh_en && !init_done, "R1 reset outputs",
        {cke, cmd_valid, refresh_en, init_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cke && !cmd_valid && !refresh_en && !init_done, "R1 first cycle",
        {cke, cmd_valid, refresh_en, init_done}, 0);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !init_done; i++) @(negedge clk);
    chk(init_done, "R11 init_done reached", init_done, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic verify_seq(input bit two, input bit gaps);
    int exp_n;
    exp_n = two ? 24 : 12;
    chk(n_hs == exp_n, "R10 command count", n_hs, exp_n);
    for (int i = 0; i < n_hs && i < exp_n; i++) begin
      logic [19:0] e;
      e = exp_cmd(i % 12, mr_val, emr1_val, emr2_val, emr3_val);
      chk({h_typ[i], h_bank[i], h_addr[i]} == e, step_req(i % 12),
          {h_typ[i], h_bank[i], h_addr[i]}, e);
      chk(h_chip[i] == (i >= 12), "R10 chip", h_chip[i], (i >= 12));
      if (gaps && i > 0) begin
        int g;
        g = (i % 12 == 1) ? CKE_W : ((i % 12 == 10) ? MRS_W : 0);
        chk(h_cyc[i] - h_cyc[i-1] - 1 == g, (i % 12 == 10) ? "R7 wait" : "R6 spacing",
            h_cyc[i] - h_cyc[i-1] - 1, g);
      end
    end
    chk(cke_rise == nop_hs + 1, "R5 cke rise", cke_rise, nop_hs + 1);
    chk(done_cyc == h_cyc[n_hs-1] + 1, "R11 done cycle", done_cyc, h_cyc[n_hs-1] + 1);
    chk(refresh_en && init_done && cke, "R11 flags held", {refresh_en, init_done, cke}, 7);
    chk(post_err == 0, "R11 no command after done", post_err, 0);
    chk(stab_err == 0, "R3 payload hold", stab_err, 0);
  endtask

  task automatic test_single_rank();
    bp_on = 0; two_rank_en = 0; dll_locked = 1;
    mr_val = 14'h0442; emr1_val = 14'h0400; emr2_val = 14'h0080; emr3_val = 14'h0000;
    do_reset();
    wait_done(3000);
    chk(first_v == PWRUP + 1, "R2 power-up wait", first_v, PWRUP + 1);
    verify_seq(0, 1);
  endtask

  task automatic test_late_lock();
    bp_on = 0; two_rank_en = 0; dll_locked = 0;
    mr_val = 14'h0542; emr1_val = 14'h0781; emr2_val = 14'h0000; emr3_val = 14'h0011;
    do_reset();
    while (cyc < 300) begin
      chk(!cmd_valid && !cke, "R2 idle before lock", {cmd_valid, cke}, 0);
      @(negedge clk);
    end
    @(posedge clk); #2 dll_locked = 1;
    wait_done(3000);
    chk(first_v == 302, "R2 late lock", first_v, 302);
    verify_seq(0, 1);
  endtask

  task automatic test_two_rank_bp();
    bp_on = 1; two_rank_en = 1; dll_locked = 1;
    mr_val = 14'h0542; emr1_val = 14'h0781; emr2_val = 14'h3FFF; emr3_val = 14'h1234;
    do_reset();
    wait_done(6000);
    verify_seq(1, 0);
    bp_on = 0;
  endtask

  task automatic test_two_rank_gaps();
    bp_on = 0; two_rank_en = 1; dll_locked = 1;
    mr_val = 14'h0663; emr1_val = 14'h0044; emr2_val = 14'h0008; emr3_val = 14'h0002;
    do_reset();
    wait_done(6000);
    verify_seq(1, 1);
  endtask

  initial begin
    test_single_rank();
    test_late_lock();
    test_two_rank_bp();
    test_two_rank_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule